// File: doc/BRIEF.md
# Load-Store Ordering Violation Predictor

This block tracks in-flight loads and stores of an out-of-order core. It keeps them in two circular queues ordered by program age, and it notices when a store resolves its address onto a doubleword that a younger load has already read. In that case it reports the load as the restart point. It trims both queues back to that load. It also sets a bit in a small wait table indexed by the load's PC.

A load allocated later whose PC hits a set bit in the wait table is marked delayed. The `ld_hold` vector holds such a load back from issue while any older store still has no address. The whole wait table is wiped on a fixed period, so a load that stopped conflicting regains full speculation. The queues release entries only when the core retires them in order. Data paths and store-to-load forwarding are not part of this block.

Top module: `lsq_wait_pred`

## Requirements
- R1: After reset both queues are empty, `ld_alloc_idx` and `st_alloc_idx` are 0, `ld_full`, `st_full`, `sq_v` and every bit of `ld_hold` are 0.
- R2: Each accepted allocation takes the slot shown on the alloc index port, and that index then advances by one modulo the depth. At LQ loads (or SQ stores) the full flag is 1, and a further allocation is ignored: the index does not move and the flag stays 1.
- R3: When a store resolves to an address whose bits above bit 2 equal those of a younger, already executed load, then on the next cycle `sq_v` is 1 for exactly one cycle, with `sq_ld_idx` set to that load's slot and `sq_pc` set to its PC.
- R4: No squash is raised when the matching load is older than the store or has not executed. No squash is raised when the addresses differ above bit 2.
- R5: When several younger executed loads match the resolving store, the one oldest in program order is reported.
- R6: A squash drops the reported load and all younger loads, so `ld_alloc_idx` equals `sq_ld_idx`. It drops every store allocated after that load, so `st_alloc_idx` returns to the store tail that the load saw at allocation. A store allocated in the same cycle as a load counts as older than it.
- R7: A squash sets the wait table bit at PC bits [TW+1:2]. A load allocated later with a set bit drives its `ld_hold` bit to 1 while it is unexecuted and any older store is unresolved. The bit falls the cycle after the last such store resolves. Loads whose bit is clear never hold.
- R8: The whole wait table is cleared every CLR_PERIOD cycles counted from reset. After a clear, a load with a formerly marked PC does not hold.
- R9: Retiring frees the oldest entry of a queue, so a full queue reports not full on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_alloc_v | input | 1 | Allocate a load |
| ld_alloc_pc | input | PC_W | PC of the load being allocated |
| ld_alloc_idx | output | log2(LQ) | Slot the next load takes |
| ld_full | output | 1 | Load queue full |
| st_alloc_v | input | 1 | Allocate a store |
| st_alloc_idx | output | log2(SQ) | Slot the next store takes |
| st_full | output | 1 | Store queue full |
| ld_exec_v | input | 1 | A load executed |
| ld_exec_idx | input | log2(LQ) | Slot of the executed load |
| ld_exec_addr | input | AW | Address read by the load |
| st_exec_v | input | 1 | A store resolved its address |
| st_exec_idx | input | log2(SQ) | Slot of the resolved store |
| st_exec_addr | input | AW | Address of the store |
| ld_ret_v | input | 1 | Retire the oldest load |
| st_ret_v | input | 1 | Retire the oldest store |
| ld_hold | output | LQ | Per-slot hold from issue |
| sq_v | output | 1 | Ordering violation, squash |
| sq_ld_idx | output | log2(LQ) | Slot of the restarting load |
| sq_pc | output | PC_W | PC of the restarting load |

## Verification
A wrong age snapshot or queue pointer shows up at the ports within one cycle. It appears either as a squash that should not have fired or as an alloc index that differs from the expected slot after a squash. A wait table bit that is stuck or lost shows as a wrong `ld_hold` value on the first delayed load allocated behind an unresolved store. A missed periodic clear stays hidden until a formerly marked load is allocated after the period has elapsed.

// File: rtl/lsq_wait_pred.sv
module lsq_wait_pred #(
  parameter int LQ = 32,
  parameter int SQ = 32,
  parameter int PC_W = 32,
  parameter int AW = 32,
  parameter int WT = 64,
  parameter int CLR_PERIOD = 16384
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_alloc_v,
  input  logic [PC_W-1:0]            ld_alloc_pc,
  output logic [$clog2(LQ)-1:0]      ld_alloc_idx,
  output logic                       ld_full,
  input  logic                       st_alloc_v,
  output logic [$clog2(SQ)-1:0]      st_alloc_idx,
  output logic                       st_full,
  input  logic                       ld_exec_v,
  input  logic [$clog2(LQ)-1:0]      ld_exec_idx,
  input  logic [AW-1:0]              ld_exec_addr,
  input  logic                       st_exec_v,
  input  logic [$clog2(SQ)-1:0]      st_exec_idx,
  input  logic [AW-1:0]              st_exec_addr,
  input  logic                       ld_ret_v,
  input  logic                       st_ret_v,
  output logic [LQ-1:0]              ld_hold,
  output logic                       sq_v,
  output logic [$clog2(LQ)-1:0]      sq_ld_idx,
  output logic [PC_W-1:0]            sq_pc
);
  localparam int LW = $clog2(LQ);
  localparam int SW = $clog2(SQ);
  localparam int TW = $clog2(WT);
  localparam int CW = $clog2(CLR_PERIOD);

  logic [LW:0] lh, lt, lcnt;
  logic [SW:0] sh, stl, scnt;
  logic [PC_W-1:0] lpc [LQ];
  logic [AW-1:0] ladr [LQ];
  logic [SW:0] lsnap [LQ];
  logic [LQ-1:0] lex, ldly, lin, hit;
  logic [SQ-1:0] sres, sin;
  logic [SW:0] soff [SQ];
  logic [SQ-1:0] older [LQ];
  logic [WT-1:0] wt;
  logic [CW-1:0] ccnt;
  logic clr, vfound, ld_take, st_take;
  logic [LW-1:0] voff, vidx;

  assign lcnt = lt - lh;
  assign scnt = stl - sh;
  assign ld_full = lcnt == (LW+1)'(LQ);
  assign st_full = scnt == (SW+1)'(SQ);
  assign ld_alloc_idx = lt[LW-1:0];
  assign st_alloc_idx = stl[SW-1:0];
  assign clr = ccnt == CW'(CLR_PERIOD-1);
  assign ld_take = ld_alloc_v && !ld_full && !vfound;
  assign st_take = st_alloc_v && !st_full && !vfound;

  for (genvar j = 0; j < SQ; j++) begin : g_st
    assign soff[j] = {1'b0, SW'(j) - sh[SW-1:0]};
    assign sin[j] = soff[j] < scnt;
  end

  for (genvar i = 0; i < LQ; i++) begin : g_ld
    logic [LW:0] off;
    logic [SW:0] lim;
    assign off = {1'b0, LW'(i) - lh[LW-1:0]};
    assign lin[i] = off < lcnt;
    assign lim = lsnap[i] - sh;
    for (genvar j = 0; j < SQ; j++) begin : g_cmp
      assign older[i][j] = sin[j] && (soff[j] < lim);
    end
    assign ld_hold[i] = lin[i] && ldly[i] && !lex[i] && |(older[i] & ~sres);
    assign hit[i] = st_exec_v && lin[i] && lex[i] && older[i][st_exec_idx] &&
                    (((ladr[i] ^ st_exec_addr) >> 3) == '0);
  end

  always_comb begin
    vfound = 1'b0;
    voff = '0;
    for (int k = 0; k < LQ; k++) begin
      if (!vfound && hit[lh[LW-1:0] + LW'(k)]) begin
        vfound = 1'b1;
        voff = LW'(k);
      end
    end
  end
  assign vidx = lh[LW-1:0] + voff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lh <= '0; lt <= '0; sh <= '0; stl <= '0;
      lex <= '0; ldly <= '0; sres <= '0; wt <= '0; ccnt <= '0;
      sq_v <= 1'b0; sq_ld_idx <= '0; sq_pc <= '0;
    end else begin
      ccnt <= clr ? '0 : ccnt + 1'b1;
      if (clr) wt <= '0;
      if (vfound) wt[lpc[vidx][TW+1:2]] <= 1'b1;
      sq_v <= vfound;
      if (vfound) begin
        sq_ld_idx <= vidx;
        sq_pc <= lpc[vidx];
      end
      if (ld_exec_v) lex[ld_exec_idx] <= 1'b1;
      if (st_exec_v) sres[st_exec_idx] <= 1'b1;
      if (ld_ret_v && lcnt != '0) lh <= lh + 1'b1;
      if (st_ret_v && scnt != '0) sh <= sh + 1'b1;
      if (vfound) begin
        lt <= lh + {1'b0, voff};
        stl <= lsnap[vidx];
      end else begin
        if (ld_take) begin
          lt <= lt + 1'b1;
          lex[lt[LW-1:0]] <= 1'b0;
          ldly[lt[LW-1:0]] <= wt[ld_alloc_pc[TW+1:2]];
        end
        if (st_take) begin
          stl <= stl + 1'b1;
          sres[stl[SW-1:0]] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ld_take) begin
      lpc[lt[LW-1:0]] <= ld_alloc_pc;
      lsnap[lt[LW-1:0]] <= stl + (SW+1)'(st_take);
    end
    if (ld_exec_v) ladr[ld_exec_idx] <= ld_exec_addr;
  end

  p_ldcnt_r2: assert property (@(posedge clk) disable iff (!rst_n) lcnt <= (LW+1)'(LQ));
  p_stcnt_r2: assert property (@(posedge clk) disable iff (!rst_n) scnt <= (SW+1)'(SQ));
  p_sq_src_r3: assert property (@(posedge clk) disable iff (!rst_n) sq_v |-> $past(st_exec_v));
  p_trunc_r6: assert property (@(posedge clk) disable iff (!rst_n) sq_v |-> lt[LW-1:0] == sq_ld_idx);
  p_mark_r7: assert property (@(posedge clk) disable iff (!rst_n) sq_v |-> wt[sq_pc[TW+1:2]]);
  p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n) ($past(clr) && !sq_v) |-> wt == '0);
endmodule

// File: tb/sim_lsq_wait_pred.sv
`timescale 1ns/1ps
module sim_lsq_wait_pred;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_alloc_v = 0, st_alloc_v = 0, ld_exec_v = 0, st_exec_v = 0, ld_ret_v = 0, st_ret_v = 0;
  logic [31:0] ld_alloc_pc = 0, ld_exec_addr = 0, st_exec_addr = 0, sq_pc, ld_hold;
  logic [4:0] ld_exec_idx = 0, st_exec_idx = 0, ld_alloc_idx, st_alloc_idx, sq_ld_idx;
  logic ld_full, st_full, sq_v;
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  lsq_wait_pred u0 (.*);

  task automatic ck(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    ld_alloc_v = 0; st_alloc_v = 0; ld_exec_v = 0; st_exec_v = 0; ld_ret_v = 0; st_ret_v = 0;
  endtask
  task automatic ld_al(logic [31:0] pc); ld_alloc_v = 1; ld_alloc_pc = pc; tick(); endtask
  task automatic st_al(); st_alloc_v = 1; tick(); endtask
  task automatic ld_ex(logic [4:0] i, logic [31:0] a); ld_exec_v = 1; ld_exec_idx = i; ld_exec_addr = a; tick(); endtask
  task automatic st_ex(logic [4:0] i, logic [31:0] a); st_exec_v = 1; st_exec_idx = i; st_exec_addr = a; tick(); endtask
  task automatic ld_rt(); ld_ret_v = 1; tick(); endtask
  task automatic st_rt(); st_ret_v = 1; tick(); endtask

  task automatic t_reset();
    ck("R1 ld_idx", ld_alloc_idx, 0); ck("R1 st_idx", st_alloc_idx, 0);
    ck("R1 full", {ld_full, st_full}, 0); ck("R1 sq_v", sq_v, 0); ck("R1 hold", ld_hold, 0);
  endtask

  task automatic t_violation();
    st_al(); ld_al(32'h104);
    ck("R2 ld_idx", ld_alloc_idx, 1); ck("R2 st_idx", st_alloc_idx, 1);
    ld_ex(0, 32'h1000); st_ex(0, 32'h1004);
    ck("R3 sq_v", sq_v, 1); ck("R3 sq_ld_idx", sq_ld_idx, 0); ck("R3 sq_pc", sq_pc, 32'h104);
    ck("R6 ld_idx", ld_alloc_idx, 0); ck("R6 st_idx", st_alloc_idx, 1);
    tick(); ck("R3 pulse", sq_v, 0);
  endtask

  task automatic t_delay();
    st_al(); ld_al(32'h104); ld_al(32'h208);
    ck("R7 marked hold", ld_hold[0], 1); ck("R7 unmarked", ld_hold[1], 0);
    st_ex(1, 32'h9000);
    ck("R7 release", ld_hold, 0); ck("R4 unexec", sq_v, 0);
    ld_rt(); ld_rt(); st_rt(); st_rt();
  endtask

  task automatic t_noviol();
    ld_al(32'h30C); st_al(); ld_al(32'h310); ld_al(32'h314);
    ld_ex(2, 32'h2000); ld_ex(3, 32'h3000); st_ex(2, 32'h2000);
    ck("R4 no sq", sq_v, 0); ck("R4 ld_idx", ld_alloc_idx, 5);
    ld_rt(); ld_rt(); ld_rt(); st_rt();
  endtask

  task automatic t_oldest();
    st_al(); ld_al(32'h414); ld_al(32'h518);
    ld_ex(6, 32'h4003); ld_ex(5, 32'h4000); st_ex(3, 32'h4006);
    ck("R5 sq_v", sq_v, 1); ck("R5 oldest", sq_ld_idx, 5); ck("R5 pc", sq_pc, 32'h414);
    ck("R6 ld_idx", ld_alloc_idx, 5); ck("R6 st_idx", st_alloc_idx, 4);
    st_rt();
  endtask

  task automatic t_full();
    for (int k = 0; k < 32; k++) ld_al(32'h600);
    ck("R2 ld_full", ld_full, 1);
    ld_al(32'h600);
    ck("R2 ld ignored", ld_alloc_idx, 5); ck("R2 ld still full", ld_full, 1);
    ld_rt(); ck("R9 ld free", ld_full, 0);
    for (int k = 0; k < 31; k++) ld_rt();
    for (int k = 0; k < 32; k++) st_al();
    ck("R2 st_full", st_full, 1);
    st_al();
    ck("R2 st ignored", st_alloc_idx, 4);
    st_rt(); ck("R9 st free", st_full, 0);
    for (int k = 0; k < 31; k++) st_rt();
  endtask

  task automatic t_clear();
    logic [4:0] i;
    st_al(); i = ld_alloc_idx; ld_al(32'h414);
    ck("R7 second mark", ld_hold[i], 1);
    st_ex(4, 32'h0); ld_rt(); st_rt();
    repeat (16384) tick();
    st_al(); i = ld_alloc_idx; ld_al(32'h104);
    ck("R8 cleared", ld_hold[i], 0);
  endtask

  initial begin
    #1_000_000;
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_violation(); t_delay(); t_noviol(); t_oldest(); t_full(); t_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule